// File: doc/BRIEF.md
# Firmware Configuration Device Register Front-End

This block is the memory-mapped register file of a firmware-configuration device. Host software selects a configuration item by writing its number to a selector register, then pulls the item out one byte at a time through a data register. The block keeps the item number and the read cursor into that item. It drives both to an external item store, which returns the byte at the cursor and the length of the item.

For bulk transfers, software writes a 64-bit pointer into a pointer register that is interpreted big-endian. Writing the lower half of the pointer hands the complete pointer to an external transfer engine, with a one-cycle start pulse. A pointer that fits in 32 bits therefore needs only one write. While the engine runs, the front-end is in state `ST_BUSY`. In that state the engine owns the cursor and further triggers are refused. The engine's done pulse returns the front-end to `ST_IDLE`, clears the pointer, and loads the cursor value that the engine reports.

The state machine has two states, `ST_IDLE` and `ST_BUSY`. The transition `ST_IDLE -> ST_BUSY` is taken on a trigger, which is a narrow write to the lower half or a 64-bit write at the upper half. The transition `ST_BUSY -> ST_IDLE` is taken when the engine's done pulse arrives. The bus interface takes a request in one cycle, and a read answers with `bus_rvalid` and `bus_rdata` in the next cycle. Bus byte lanes are little-endian: the byte at the access address is `bus_wdata[7:0]`.

Top module: `cfgdev_regs`

## Requirements
- R1: After reset the selector is 0, the cursor is 0, the pointer reads 0, `dma_busy` and `dma_start` are 0, and `bus_rvalid` is 0.
- R2: `features` has bit 0 set (byte interface), bit 1 equal to the DMA_EN parameter (transfer engine present), and all other bits clear.
- R3: A narrow write at offset 0x08 in `ST_IDLE` latches `bus_wdata[15:0]` as the selector and resets the cursor to 0. A read at 0x08 returns the selector in `bus_rdata[15:0]`, with the upper bits zero.
- R4: A read at offset 0x00 in `ST_IDLE` returns the item byte at the cursor in `bus_rdata[7:0]`, with the upper bits zero. It advances the cursor by one. `bus_rvalid` is high in the cycle after every read request.
- R5: A data read with cursor >= `item_len` returns 0 and leaves the cursor unchanged.
- R6: The pointer is big-endian. Its most significant byte sits at offset 0x0C and its least significant byte at 0x13. A narrow write at 0x0C with data w sets pointer[63:32] to the byte-swapped w. Reads at 0x0C (narrow or 64-bit) and at 0x10 return the matching pointer bytes in the same order.
- R7: A narrow write at 0x10 in `ST_IDLE` sets pointer[31:0] to the byte-swapped `bus_wdata[31:0]`. In the next cycle `dma_start` is high for exactly one cycle, `dma_ptr` holds the full pointer, and `dma_busy` is high.
- R8: A 64-bit write at 0x0C in `ST_IDLE` loads the whole pointer as the byte-swapped `bus_wdata` and triggers as in R7.
- R9: A narrow write to the upper half alone never raises `dma_start`.
- R10: In `ST_BUSY`, pointer writes and selector writes have no effect. Data reads return 0 and do not move the cursor.
- R11: `dma_done` in `ST_BUSY` clears the pointer to 0, loads the cursor from `dma_off`, and drops `dma_busy` in the next cycle. `dma_done` in `ST_IDLE` is ignored.
- R12: Reads at unmapped offsets (0x04, 0x14 and above, and a 64-bit read at 0x10) return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit or narrower |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 64 | Write data, little-endian lanes |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 64 | Read data |
| features | output | 32 | Feature bitmap |
| item_sel | output | SEL_W | Selected item number |
| item_off | output | OFF_W | Read cursor within the item |
| item_len | input | OFF_W | Byte length of the selected item |
| item_byte | input | 8 | Item byte at the cursor |
| dma_start | output | 1 | One-cycle transfer start pulse |
| dma_ptr | output | 64 | Pointer handed to the engine |
| dma_busy | output | 1 | High in `ST_BUSY` |
| dma_done | input | 1 | Engine finished |
| dma_off | input | OFF_W | Cursor value at the end of the transfer |

## Verification
A wrong state flag would first show on a trigger: a front-end stuck in `ST_BUSY` refuses the next pointer write, and `dma_start` stays low in the cycle after it. The same fault also makes the next data read return zero. A cursor that is off by one appears as a wrong byte on the very next data read, and a cursor that misses the end of the item appears as a nonzero byte past the item end. A byte-order fault in the pointer path shows on `dma_ptr` in the cycle after the trigger, and on any pointer read in the cycle after its request.

// File: rtl/cfgdev_pkg.sv
package cfgdev_pkg;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_DATA,
        REG_SEL,
        REG_PTR_HI,
        REG_PTR_LO
    } reg_id_t;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } dma_state_t;

    localparam logic [4:0] OFS_DATA   = 5'h00;
    localparam logic [4:0] OFS_SEL    = 5'h08;
    localparam logic [4:0] OFS_PTR_HI = 5'h0C;
    localparam logic [4:0] OFS_PTR_LO = 5'h10;

    function automatic logic [31:0] swap32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = v[8*(3-i) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] swap64(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
        return r;
    endfunction

endpackage

// File: rtl/cfgdev_decode.sv
module cfgdev_decode
    import cfgdev_pkg::*;
#(
    parameter bit DMA_EN = 1'b1
) (
    input  logic [4:0] addr,
    input  logic       wide,
    output reg_id_t    reg_id
);
    always_comb begin
        reg_id = REG_NONE;
        if (addr == OFS_DATA)
            reg_id = REG_DATA;
        else if (addr == OFS_SEL && !wide)
            reg_id = REG_SEL;
        else if (DMA_EN && addr == OFS_PTR_HI)
            reg_id = REG_PTR_HI;
        else if (DMA_EN && addr == OFS_PTR_LO && !wide)
            reg_id = REG_PTR_LO;
    end
endmodule

// File: rtl/cfgdev_cursor.sv
module cfgdev_cursor #(
    parameter int SEL_W = 16,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_val,
    input  logic             rd_step,
    input  logic             load_off,
    input  logic [OFF_W-1:0] load_val,
    input  logic [OFF_W-1:0] item_len,
    output logic [SEL_W-1:0] sel,
    output logic [OFF_W-1:0] off,
    output logic             at_end
);
    assign at_end = (off >= item_len);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            off <= '0;
        end else if (load_off) begin
            off <= load_val;
        end else if (sel_wr) begin
            sel <= sel_val;
            off <= '0;
        end else if (rd_step && !at_end) begin
            off <= off + 1'b1;
        end
    end

    // R3
    sel_wr_clears_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !load_off) |=> (off == '0));

    // R4
    rd_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !at_end && !load_off) |=> (off == $past(off) + 1'b1));

    // R5
    end_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && at_end && !load_off) |=> $stable(off));
endmodule

// File: rtl/cfgdev_dma_ptr.sv
module cfgdev_dma_ptr
    import cfgdev_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hi,
    input  logic        wr_lo,
    input  logic        wr_full,
    input  logic [63:0] wdata,
    input  logic        done,
    output logic [63:0] ptr,
    output logic        busy,
    output logic        start
);
    dma_state_t state, state_nx;
    logic       trig;

    assign trig = (state == ST_IDLE) && (wr_lo || wr_full);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (trig) state_nx = ST_BUSY;
            ST_BUSY: if (done) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            start <= 1'b0;
        end else begin
            start <= trig;
            unique case (state)
                ST_IDLE: begin
                    if (wr_full)    ptr         <= swap64(wdata);
                    else if (wr_hi) ptr[63:32]  <= swap32(wdata[31:0]);
                    else if (wr_lo) ptr[31:0]   <= swap32(wdata[31:0]);
                end
                ST_BUSY: begin
                    if (done) ptr <= '0;
                end
            endcase
        end
    end

    assign busy = (state == ST_BUSY);

    // R7
    start_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R7
    start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> busy);

    // R11
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> (ptr == '0 && !busy));

    // R10
    busy_holds_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(ptr));

    // R9
    hi_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo && !wr_full) |=> !start);
endmodule

// File: rtl/cfgdev_regs.sv
module cfgdev_regs
    import cfgdev_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int OFF_W  = 16,
    parameter bit DMA_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic             bus_wide,
    input  logic [4:0]       bus_addr,
    input  logic [63:0]      bus_wdata,
    output logic             bus_rvalid,
    output logic [63:0]      bus_rdata,
    output logic [31:0]      features,
    output logic [SEL_W-1:0] item_sel,
    output logic [OFF_W-1:0] item_off,
    input  logic [OFF_W-1:0] item_len,
    input  logic [7:0]       item_byte,
    output logic             dma_start,
    output logic [63:0]      dma_ptr,
    output logic             dma_busy,
    input  logic             dma_done,
    input  logic [OFF_W-1:0] dma_off
);
    localparam int SEL_PAD = 64 - SEL_W;

    reg_id_t    reg_id;
    logic       rd, wr, at_end;
    logic       sel_wr, rd_step, load_off;
    logic       wr_hi, wr_lo, wr_full;
    logic [63:0] ptr;
    logic [63:0] rd_mux;

    assign features = {30'd0, DMA_EN, 1'b1};

    cfgdev_decode #(.DMA_EN(DMA_EN)) u_decode (
        .addr   (bus_addr),
        .wide   (bus_wide),
        .reg_id (reg_id)
    );

    assign rd       = bus_req && !bus_we;
    assign wr       = bus_req &&  bus_we;
    assign sel_wr   = wr && (reg_id == REG_SEL)    && !dma_busy;
    assign rd_step  = rd && (reg_id == REG_DATA)   && !dma_busy;
    assign wr_hi    = wr && (reg_id == REG_PTR_HI) && !bus_wide;
    assign wr_full  = wr && (reg_id == REG_PTR_HI) &&  bus_wide;
    assign wr_lo    = wr && (reg_id == REG_PTR_LO);
    assign load_off = dma_busy && dma_done;

    cfgdev_cursor #(.SEL_W(SEL_W), .OFF_W(OFF_W)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_wr   (sel_wr),
        .sel_val  (bus_wdata[SEL_W-1:0]),
        .rd_step  (rd_step),
        .load_off (load_off),
        .load_val (dma_off),
        .item_len (item_len),
        .sel      (item_sel),
        .off      (item_off),
        .at_end   (at_end)
    );

    generate
        if (DMA_EN) begin : g_dma
            cfgdev_dma_ptr u_ptr (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_hi   (wr_hi),
                .wr_lo   (wr_lo),
                .wr_full (wr_full),
                .wdata   (bus_wdata),
                .done    (dma_done),
                .ptr     (ptr),
                .busy    (dma_busy),
                .start   (dma_start)
            );
        end else begin : g_nodma
            assign ptr       = '0;
            assign dma_busy  = 1'b0;
            assign dma_start = 1'b0;
        end
    endgenerate

    assign dma_ptr = ptr;

    always_comb begin
        rd_mux = '0;
        unique case (reg_id)
            REG_DATA:   rd_mux = (dma_busy || at_end) ? 64'd0 : {56'd0, item_byte};
            REG_SEL:    rd_mux = {{SEL_PAD{1'b0}}, item_sel};
            REG_PTR_HI: rd_mux = bus_wide ? swap64(ptr) : {32'd0, swap32(ptr[63:32])};
            REG_PTR_LO: rd_mux = {32'd0, swap32(ptr[31:0])};
            REG_NONE:   rd_mux = '0;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd;
            if (rd) bus_rdata <= rd_mux;
        end
    end

    // R4
    rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);

    // R10
    busy_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && reg_id == REG_DATA && dma_busy) |=> (bus_rdata == '0));

    // R2
    features_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (features[0] && $countones(features) <= 2));
endmodule

// File: tb/cfgdev_regs_bench.sv
module cfgdev_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [63:0] bus_rdata;
    logic [31:0] features;
    logic [15:0] item_sel, item_off, item_len, dma_off = '0;
    logic [7:0]  item_byte;
    logic        dma_start, dma_busy, dma_done = 1'b0;
    logic [63:0] dma_ptr;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_sel = '0, m_off = '0;
    logic [63:0] m_ptr = '0;
    logic        m_busy = 1'b0;
    logic [63:0] r_data;
    logic        r_valid, r_start;

    always #5 clk = ~clk;

    function automatic logic [15:0] f_len(input logic [15:0] s);
        return {12'd0, s[3:0]} + 16'd3;
    endfunction
    function automatic logic [7:0] f_byte(input logic [15:0] s, input logic [15:0] o);
        return s[7:0] ^ o[7:0] ^ 8'hA5;
    endfunction
    function automatic logic [31:0] bs32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction
    function automatic logic [63:0] bs64(input logic [63:0] v);
        return {bs32(v[31:0]), bs32(v[63:32])};
    endfunction

    assign item_len  = f_len(item_sel);
    assign item_byte = f_byte(item_sel, item_off);

    cfgdev_regs u_cfgdev_regs (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .features(features),
        .item_sel(item_sel), .item_off(item_off), .item_len(item_len),
        .item_byte(item_byte), .dma_start(dma_start), .dma_ptr(dma_ptr),
        .dma_busy(dma_busy), .dma_done(dma_done), .dma_off(dma_off)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic wide, input logic [4:0] a,
                          input logic [63:0] wd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_wide = wide; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        r_data = bus_rdata; r_valid = bus_rvalid; r_start = dma_start;
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " sel"}, {48'd0, item_sel}, {48'd0, m_sel});
        chk({tag, " off"}, {48'd0, item_off}, {48'd0, m_off});
        chk({tag, " busy"}, {63'd0, dma_busy}, {63'd0, m_busy});
    endtask

    // Model-driven operations
    task automatic op_sel_wr(input logic [15:0] v);
        bus_op(1'b1, 1'b0, 5'h08, {48'hDEAD_BEEF_0000, v});
        if (!m_busy) begin m_sel = v; m_off = '0; end
        chk_state("R3/R10 sel write");
    endtask

    task automatic op_data_rd();
        logic [63:0] e;
        e = (!m_busy && m_off < f_len(m_sel)) ? {56'd0, f_byte(m_sel, m_off)} : 64'd0;
        bus_op(1'b0, 1'b0, 5'h00, '0);
        chk("R4/R5/R10 data read", r_data, e);
        chk("R4 rvalid", {63'd0, r_valid}, 64'd1);
        if (!m_busy && m_off < f_len(m_sel)) m_off = m_off + 1;
        chk_state("R4/R5 cursor");
    endtask

    task automatic op_ptr_wr(input int kind, input logic [63:0] w);
        logic trig;
        trig = !m_busy && kind != 0;
        if (!m_busy) begin
            if (kind == 0) m_ptr[63:32] = bs32(w[31:0]);
            else if (kind == 1) m_ptr[31:0] = bs32(w[31:0]);
            else m_ptr = bs64(w);
        end
        bus_op(1'b1, kind == 2, kind == 1 ? 5'h10 : 5'h0C, w);
        chk("R7/R8/R9/R10 start", {63'd0, r_start}, {63'd0, trig});
        if (trig) begin
            m_busy = 1'b1;
            chk("R7/R8 dma_ptr", dma_ptr, m_ptr);
        end
        chk_state("R7/R10 ptr write");
    endtask

    task automatic op_ptr_rd(input int kind);
        logic [63:0] e;
        if (kind == 0) e = {32'd0, bs32(m_ptr[63:32])};
        else if (kind == 1) e = {32'd0, bs32(m_ptr[31:0])};
        else e = bs64(m_ptr);
        bus_op(1'b0, kind == 2, kind == 1 ? 5'h10 : 5'h0C, '0);
        chk("R6 ptr read", r_data, e);
    endtask

    task automatic op_done(input logic [15:0] o);
        @(negedge clk);
        dma_done = 1'b1; dma_off = o;
        @(negedge clk);
        dma_done = 1'b0;
        if (m_busy) begin m_busy = 1'b0; m_ptr = '0; m_off = o; end
        chk_state("R11 done");
        chk("R11 ptr", dma_ptr, m_ptr);
    endtask

    task automatic op_unmapped(input logic we, input logic [4:0] a, input logic [63:0] w);
        bus_op(we, a == 5'h10, a, w);
        if (!we) chk("R12 unmapped read", r_data, 64'd0);
        chk_state("R12 unmapped");
        chk("R12 ptr", dma_ptr, m_ptr);
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {63'd0, dma_busy}, 64'd0);
        chk("R1 start", {63'd0, dma_start}, 64'd0);
        chk("R1 rvalid", {63'd0, bus_rvalid}, 64'd0);
        chk("R1 ptr", dma_ptr, 64'd0);
        chk_state("R1");
        // R2 features
        chk("R2 features", {32'd0, features}, 64'd3);

        // R3 / R4 / R5 directed: item 1 has 4 bytes
        op_sel_wr(16'h0001);
        bus_op(1'b0, 1'b0, 5'h08, '0);
        chk("R3 sel read", r_data, 64'd1);
        for (int i = 0; i < 6; i++) op_data_rd();
        // R6 / R9 upper only
        op_ptr_wr(0, 64'h0000_0000_1122_3344);
        op_ptr_rd(0);
        op_ptr_rd(2);
        // R7 lower triggers
        op_ptr_wr(1, 64'h0000_0000_5566_7788);
        chk("R7 dma_ptr value", dma_ptr, 64'h4433_2211_8877_6655);
        // R10 busy hold-off
        op_ptr_wr(1, 64'h0000_0000_FFFF_FFFF);
        op_sel_wr(16'h0007);
        op_data_rd();
        // R11 done
        op_done(16'h0002);
        op_ptr_rd(2);
        op_done(16'h0009);    // R11 idle done ignored
        op_data_rd();
        // R8 full write
        op_ptr_wr(2, 64'h0102_0304_0506_0708);
        chk("R8 dma_ptr value", dma_ptr, 64'h0807_0605_0403_0201);
        op_done(16'h0000);
        // R12 unmapped
        op_unmapped(1'b0, 5'h04, '0);
        op_unmapped(1'b0, 5'h14, '0);
        op_unmapped(1'b0, 5'h10, '0);
        op_unmapped(1'b1, 5'h18, 64'hFFFF_FFFF_FFFF_FFFF);
        op_unmapped(1'b1, 5'h04, 64'h0000_0000_0000_0055);

        // random phase
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom_range(0, 9);
            case (k)
                0: op_sel_wr({12'd0, 4'($urandom_range(0, 15))});
                1, 2: op_data_rd();
                3: op_ptr_wr(0, {32'd0, $urandom});
                4: op_ptr_wr(1, {32'd0, $urandom});
                5: op_ptr_wr(2, {$urandom, $urandom});
                6: op_ptr_rd($urandom_range(0, 2));
                7: op_done(16'($urandom_range(0, 20)));
                8: begin
                    bus_op(1'b0, 1'b0, 5'h08, '0);
                    chk("R3 sel read", r_data, {48'd0, m_sel});
                end
                default: op_unmapped($urandom_range(0, 1) == 1, 5'h14, {$urandom, $urandom});
            endcase
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule